// File: doc/BRIEF.md
# Load/Store Alignment Fault Detector

This block screens every load or store request before the instruction starts and decides whether it has to raise an alignment exception. The pipeline supplies the effective address, the operand size, a 3-bit operation class, the little-endian mode bit, the address-translation attributes (translation enabled, segment direct-store bit, block-translation hit) and the page write-through and cache-inhibit attributes. The detector applies the fault rules for each class. It then returns the fault flag, the data address to record for the handler, and a 32-bit syndrome word assembled from fields of the instruction word.

Results come out of a single register stage, one cycle after a request strobe. Because the decision is made before any part of the memory operation happens, the issue logic can use the flag to cancel the access outright. Misaligned accesses that do not fault are passed on without comment; splitting them into several cache accesses is handled elsewhere.

Bit numbers for the syndrome and the instruction word below are big-endian: bit 0 is the MSB, so big-endian bit k is vector index 31-k. Operand size codes are 0 byte, 1 halfword, 2 word, 3 doubleword. Class codes are 0 integer, 1 floating-point, 2 load/store multiple, 3 string, 4 load-reserve/conditional-store, 5 cache-block zero. Codes 6 and 7 are unused. Page-translation mode means translation on, segment bit clear and no block-translation hit. A misaligned address is one that is not a multiple of the operand size.

Top module: `aln_fault_detect`

## Requirements
- R1: An integer access (class 0) in page-translation mode faults only when it would run past the end of a 4 KB page. A byte never faults. A halfword faults at page offset 0xFFF, a word at 0xFFD-0xFFF and a doubleword at 0xFF9-0xFFF. Outside page-translation mode, a big-endian integer access never faults.
- R2: A floating-point access (class 1) faults whenever address bits [1:0] are not zero.
- R3: A load/store multiple (class 2) or reserve/conditional-store (class 4) faults whenever address bits [1:0] are not zero.
- R4: With little-endian mode set, a misaligned integer, floating-point or reserve access faults. Every multiple or string access (classes 2, 3) faults, whatever its address.
- R5: A cache-block zero (class 5) faults if and only if the page is write-through or cache-inhibited, whatever its address or endian mode.
- R6: On a fault, rsp_dar equals the effective address, or the effective address plus 4 (modulo 2^32) for class 2.
- R7: On a fault from an indexed form (req_indexed=1), syndrome bits 0-14 are zero. Bits 15-16 take instruction bits 29-30, bit 17 takes bit 25, bits 18-21 take bits 21-24, bits 22-26 take bits 6-10 and bits 27-31 take bits 11-15.
- R8: On a fault from an immediate-offset form (req_indexed=0), syndrome bits 0-16 are zero. Bit 17 takes instruction bit 5, bits 18-21 take bits 1-4, bits 22-26 take bits 6-10 and bits 27-31 take bits 11-15.
- R9: rsp_valid is high exactly in the cycle after req_valid is high. Back-to-back requests give back-to-back results. rsp_fault is never high without rsp_valid. Without a fault, rsp_dar and rsp_syn are zero.
- R10: While reset is low, and in the first cycle after it, rsp_valid, rsp_fault, rsp_dar and rsp_syn are zero.
- R11: Class codes 6 and 7 never fault, whatever the address, size or modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one per access |
| req_ea | input | ADDR_W | Effective address |
| req_size | input | 2 | Operand size code |
| req_class | input | 3 | Operation class code |
| req_insn | input | 32 | Instruction word |
| req_indexed | input | 1 | 1 = indexed form, 0 = immediate-offset form |
| le_mode | input | 1 | Little-endian mode |
| xlate_on | input | 1 | Data translation enabled |
| seg_t | input | 1 | Segment direct-store bit |
| bat_hit | input | 1 | Block-translation match |
| page_wt | input | 1 | Page is write-through |
| page_ci | input | 1 | Page is cache-inhibited |
| rsp_valid | output | 1 | Result strobe |
| rsp_fault | output | 1 | Alignment exception |
| rsp_dar | output | ADDR_W | Fault data address |
| rsp_syn | output | 32 | Fault syndrome |

## Verification
A wrong fault decision (a bad page-offset limit, a class decode that is off, a missing little-endian term) shows on rsp_fault in the very next cycle after the request. Each such case is one request, so a single bad boundary offset is exposed right away. An offset error in the address adjustment, or a swapped field in the syndrome, appears in rsp_dar or rsp_syn in that same response cycle. The scoreboard compares all three outputs there. A stale register shows as nonzero address or syndrome on a non-faulting response, or as rsp_valid lasting one cycle too long.

// File: rtl/aln_pkg.sv
package aln_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_DBL  = 2'd3;

  localparam logic [2:0] OP_INT    = 3'd0;
  localparam logic [2:0] OP_FP     = 3'd1;
  localparam logic [2:0] OP_MULTI  = 3'd2;
  localparam logic [2:0] OP_STRING = 3'd3;
  localparam logic [2:0] OP_RSV    = 3'd4;
  localparam logic [2:0] OP_CBZ    = 3'd5;

  localparam int SYN_W  = 32;
  localparam int INSN_W = 32;

  // bytes touched by an operand of the given size code
  function automatic logic [3:0] size_bytes(input logic [1:0] sz);
    return 4'd1 << sz;
  endfunction

  // low-order address bits that must be zero for a natural alignment
  function automatic logic nat_misaligned(input logic [2:0] ea_lo, input logic [1:0] sz);
    logic [2:0] mask;
    mask = 3'(size_bytes(sz) - 4'd1);
    return |(ea_lo & mask);
  endfunction

  // instruction or syndrome bit in big-endian numbering
  function automatic int be_idx(input int k);
    return 31 - k;
  endfunction
endpackage

// File: rtl/aln_page_cross.sv
module aln_page_cross
  import aln_pkg::*;
#(
  parameter int PAGE_BITS = 12
) (
  input  logic [PAGE_BITS-1:0] page_off,
  input  logic [1:0]           size,
  output logic                 crosses
);
  localparam int PW = PAGE_BITS + 1;
  localparam logic [PW-1:0] PAGE_BYTES = PW'(1) << PAGE_BITS;

  logic [PW-1:0] last_ok;   // highest offset where the operand still fits
  logic [PW-1:0] off_ext;

  assign off_ext = {1'b0, page_off};
  assign last_ok = PAGE_BYTES - PW'(size_bytes(size));
  assign crosses = off_ext > last_ok;
endmodule

// File: rtl/aln_rule_eval.sv
module aln_rule_eval
  import aln_pkg::*;
#(
  parameter int PAGE_BITS = 12
) (
  input  logic [PAGE_BITS-1:0] ea_off,
  input  logic [1:0]           size,
  input  logic [2:0]           op_class,
  input  logic                 le_mode,
  input  logic                 xlate_on,
  input  logic                 seg_t,
  input  logic                 bat_hit,
  input  logic                 page_wt,
  input  logic                 page_ci,
  output logic                 fault,
  output logic                 is_multi
);
  logic page_mode;
  logic page_cross;
  logic word_mis;
  logic nat_mis;
  logic is_int, is_fp, is_str, is_rsv, is_cbz;
  logic f_int_cross, f_word, f_le_mis, f_le_bulk, f_cbz;

  assign page_mode = xlate_on & ~seg_t & ~bat_hit;

  aln_page_cross #(.PAGE_BITS(PAGE_BITS)) cross_i (
    .page_off (ea_off),
    .size     (size),
    .crosses  (page_cross)
  );

  assign word_mis = |ea_off[1:0];
  assign nat_mis  = nat_misaligned(ea_off[2:0], size);

  assign is_int   = op_class == OP_INT;
  assign is_fp    = op_class == OP_FP;
  assign is_multi = op_class == OP_MULTI;
  assign is_str   = op_class == OP_STRING;
  assign is_rsv   = op_class == OP_RSV;
  assign is_cbz   = op_class == OP_CBZ;

  assign f_int_cross = is_int & page_mode & page_cross;
  assign f_word      = (is_fp | is_multi | is_rsv) & word_mis;
  assign f_le_mis    = le_mode & (is_int | is_fp | is_rsv) & nat_mis;
  assign f_le_bulk   = le_mode & (is_multi | is_str);
  assign f_cbz       = is_cbz & (page_wt | page_ci);

  assign fault = f_int_cross | f_word | f_le_mis | f_le_bulk | f_cbz;
endmodule

// File: rtl/aln_syndrome_build.sv
module aln_syndrome_build
  import aln_pkg::*;
(
  input  logic              fault,
  input  logic              indexed,
  input  logic [INSN_W-1:0] insn,
  output logic [SYN_W-1:0]  syn
);
  logic unused_insn_bits;
  assign unused_insn_bits = ^{insn[31], insn[15:11], insn[5:3], insn[0]};

  always_comb begin
    syn = '0;
    if (fault) begin
      for (int k = 0; k < 5; k++) begin
        syn[be_idx(22 + k)] = insn[be_idx(6 + k)];
        syn[be_idx(27 + k)] = insn[be_idx(11 + k)];
      end
      if (indexed) begin
        syn[be_idx(15)] = insn[be_idx(29)];
        syn[be_idx(16)] = insn[be_idx(30)];
        syn[be_idx(17)] = insn[be_idx(25)];
        for (int k = 0; k < 4; k++) syn[be_idx(18 + k)] = insn[be_idx(21 + k)];
      end else begin
        syn[be_idx(17)] = insn[be_idx(5)];
        for (int k = 0; k < 4; k++) syn[be_idx(18 + k)] = insn[be_idx(1 + k)];
      end
    end
  end
endmodule

// File: rtl/aln_fault_detect.sv
module aln_fault_detect
  import aln_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int MULTI_ADJ = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_ea,
  input  logic [1:0]        req_size,
  input  logic [2:0]        req_class,
  input  logic [31:0]       req_insn,
  input  logic              req_indexed,
  input  logic              le_mode,
  input  logic              xlate_on,
  input  logic              seg_t,
  input  logic              bat_hit,
  input  logic              page_wt,
  input  logic              page_ci,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [ADDR_W-1:0] rsp_dar,
  output logic [31:0]       rsp_syn
);
  logic              fault_comb;
  logic              multi_comb;
  logic [ADDR_W-1:0] dar_comb;
  logic [SYN_W-1:0]  syn_comb;

  aln_rule_eval #(.PAGE_BITS(PAGE_BITS)) rules_i (
    .ea_off   (req_ea[PAGE_BITS-1:0]),
    .size     (req_size),
    .op_class (req_class),
    .le_mode  (le_mode),
    .xlate_on (xlate_on),
    .seg_t    (seg_t),
    .bat_hit  (bat_hit),
    .page_wt  (page_wt),
    .page_ci  (page_ci),
    .fault    (fault_comb),
    .is_multi (multi_comb)
  );

  aln_syndrome_build syn_i (
    .fault   (fault_comb),
    .indexed (req_indexed),
    .insn    (req_insn),
    .syn     (syn_comb)
  );

  always_comb begin
    dar_comb = '0;
    if (fault_comb) dar_comb = multi_comb ? req_ea + ADDR_W'(MULTI_ADJ) : req_ea;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_dar   <= '0;
      rsp_syn   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid & fault_comb;
      rsp_dar   <= req_valid ? dar_comb : '0;
      rsp_syn   <= req_valid ? syn_comb : '0;
    end
  end
endmodule

// File: rtl/aln_fault_detect_chk.sv
module aln_fault_detect_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_ea,
  input logic [1:0]        req_size,
  input logic [2:0]        req_class,
  input logic              le_mode,
  input logic              page_wt,
  input logic              page_ci,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [ADDR_W-1:0] rsp_dar,
  input logic [31:0]       rsp_syn
);
  assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_rsp_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_fault_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_valid);
  assert_quiet_without_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_fault |-> (rsp_dar == '0 && rsp_syn == '0));
  assert_syn_top_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_syn[31:17] == 15'd0);
  assert_byte_int_be_safe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == 3'd0 && req_size == 2'd0 && !le_mode) |=> !rsp_fault);
  assert_fp_unaligned_faults_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == 3'd1 && req_ea[1:0] != 2'b00) |=> rsp_fault);
  assert_cbz_plain_page_safe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == 3'd5 && !page_wt && !page_ci) |=> !rsp_fault);
  assert_multi_dar_plus4_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_class == 3'd2) |=>
      (!rsp_fault || rsp_dar == $past(req_ea) + ADDR_W'(4)));
endmodule

bind aln_fault_detect aln_fault_detect_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ea    (req_ea),
  .req_size  (req_size),
  .req_class (req_class),
  .le_mode   (le_mode),
  .page_wt   (page_wt),
  .page_ci   (page_ci),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault),
  .rsp_dar   (rsp_dar),
  .rsp_syn   (rsp_syn)
);

// File: tb/aln_fault_detect_tb_top.sv
`timescale 1ns/1ps
module aln_fault_detect_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_ea = '0;
  logic [1:0]  req_size = '0;
  logic [2:0]  req_class = '0;
  logic [31:0] req_insn = '0;
  logic        req_indexed = 1'b0;
  logic        le_mode = 1'b0, xlate_on = 1'b0, seg_t = 1'b0, bat_hit = 1'b0;
  logic        page_wt = 1'b0, page_ci = 1'b0;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_dar, rsp_syn;

  int checks = 0;
  int failures = 0;

  logic        q_fault[$];
  logic [31:0] q_dar[$];
  logic [31:0] q_syn[$];
  string       q_tag[$];

  localparam logic [31:0] INSN_A = 32'hA5C3_96E1;
  localparam logic [31:0] INSN_B = 32'h3E71_4B2C;

  always #5 clk = ~clk;

  aln_fault_detect dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
    .req_size(req_size), .req_class(req_class), .req_insn(req_insn),
    .req_indexed(req_indexed), .le_mode(le_mode), .xlate_on(xlate_on),
    .seg_t(seg_t), .bat_hit(bat_hit), .page_wt(page_wt), .page_ci(page_ci),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_dar(rsp_dar), .rsp_syn(rsp_syn)
  );

  function automatic logic model_fault(input logic [31:0] ea, input int sz, input int cls,
                                       input logic le, input logic xl, input logic t,
                                       input logic bat, input logic wt, input logic ci);
    int nb;
    int off;
    logic off_nat;
    nb = 1 << sz;
    off = int'(ea & 32'hFFF);
    off_nat = (ea % nb) != 0;
    case (cls)
      0: return (xl && !t && !bat && (off + nb > 4096)) || (le && off_nat);
      1: return (ea % 4 != 0) || (le && off_nat);
      2: return (ea % 4 != 0) || le;
      3: return le;
      4: return (ea % 4 != 0) || (le && off_nat);
      5: return wt || ci;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] model_syn(input logic [31:0] i, input logic idx);
    logic [31:0] s;
    s = '0;
    s[4:0] = i[20:16];
    s[9:5] = i[25:21];
    if (idx) begin
      s[16:15] = i[2:1];
      s[14]    = i[6];
      s[13:10] = i[10:7];
    end else begin
      s[14]    = i[26];
      s[13:10] = i[30:27];
    end
    return s;
  endfunction

  task automatic send(input logic [31:0] ea, input int sz, input int cls, input logic le,
                      input logic xl, input logic t, input logic bat, input logic wt,
                      input logic ci, input logic [31:0] insn, input logic idx, input string tag);
    logic f;
    @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_size = 2'(sz); req_class = 3'(cls);
    le_mode = le; xlate_on = xl; seg_t = t; bat_hit = bat; page_wt = wt; page_ci = ci;
    req_insn = insn; req_indexed = idx;
    f = model_fault(ea, sz, cls, le, xl, t, bat, wt, ci);
    q_fault.push_back(f);
    q_dar.push_back(f ? ((cls == 2) ? ea + 32'd4 : ea) : 32'd0);
    q_syn.push_back(f ? model_syn(insn, idx) : 32'd0);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (q_fault.size() == 0) begin
        failures++;
        $display("FAIL R9 unexpected rsp_valid act=1 exp=0");
      end else begin
        logic ef;
        logic [31:0] ed, es;
        string tg;
        ef = q_fault.pop_front(); ed = q_dar.pop_front();
        es = q_syn.pop_front(); tg = q_tag.pop_front();
        if (rsp_fault !== ef || rsp_dar !== ed || rsp_syn !== es) begin
          failures++;
          $display("FAIL %s act fault=%0b dar=%h syn=%h exp fault=%0b dar=%h syn=%h",
                   tg, rsp_fault, rsp_dar, rsp_syn, ef, ed, es);
        end
      end
    end
  end

  task automatic check_idle(input string tag);
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0) begin
      failures++;
      $display("FAIL %s act valid=%0b fault=%0b exp valid=0 fault=0", tag, rsp_valid, rsp_fault);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    check_idle("R10 in reset");
    @(negedge clk); rst_n = 1'b1;
    check_idle("R10 after reset");

    // R1: integer, page-translation mode, page-end boundaries
    send(32'h0000_1FFF, 0, 0, 0, 1, 0, 0, 0, 0, INSN_A, 1, "R1 byte 0xFFF");
    send(32'h0000_1FFE, 1, 0, 0, 1, 0, 0, 0, 0, INSN_A, 1, "R1 half 0xFFE");
    send(32'h0000_1FFF, 1, 0, 0, 1, 0, 0, 0, 0, INSN_A, 1, "R1 half 0xFFF");
    send(32'h0000_2FFC, 2, 0, 0, 1, 0, 0, 0, 0, INSN_A, 0, "R1 word 0xFFC");
    send(32'h0000_2FFD, 2, 0, 0, 1, 0, 0, 0, 0, INSN_A, 0, "R1 word 0xFFD");
    send(32'h0000_2FFF, 2, 0, 0, 1, 0, 0, 0, 0, INSN_B, 1, "R1 word 0xFFF");
    send(32'h0000_3FF8, 3, 0, 0, 1, 0, 0, 0, 0, INSN_A, 1, "R1 dbl 0xFF8");
    send(32'h0000_3FF9, 3, 0, 0, 1, 0, 0, 0, 0, INSN_B, 0, "R1 dbl 0xFF9");
    send(32'h0000_3FFF, 3, 0, 0, 1, 0, 0, 0, 0, INSN_A, 1, "R1 dbl 0xFFF");
    send(32'h0000_0102, 2, 0, 0, 1, 0, 0, 0, 0, INSN_A, 1, "R1 misaligned mid-page");
    send(32'h0000_4FFF, 2, 0, 0, 0, 0, 0, 0, 0, INSN_A, 1, "R1 translation off");
    send(32'h0000_4FFF, 2, 0, 0, 1, 1, 0, 0, 0, INSN_A, 1, "R1 segment bit set");
    send(32'h0000_4FFF, 3, 0, 0, 1, 0, 1, 0, 0, INSN_A, 1, "R1 block hit");
    idle(2);
    check_idle("R9 idle after burst");

    // R2 floating point
    send(32'h0000_1002, 2, 1, 0, 1, 0, 0, 0, 0, INSN_A, 1, "R2 fp word off by 2");
    send(32'h0000_1004, 2, 1, 0, 1, 0, 0, 0, 0, INSN_A, 1, "R2 fp aligned word");
    send(32'h0000_1004, 3, 1, 0, 1, 0, 0, 0, 0, INSN_A, 1, "R2 fp dbl word-aligned");
    send(32'h0000_1FFC, 3, 1, 0, 1, 0, 0, 0, 0, INSN_A, 1, "R2 fp dbl across page");
    // R3 multiple and reserve
    send(32'h0000_2001, 2, 2, 0, 1, 0, 0, 0, 0, INSN_B, 1, "R3 multiple off by 1");
    send(32'h0000_2000, 2, 2, 0, 1, 0, 0, 0, 0, INSN_B, 1, "R3 multiple aligned");
    send(32'h0000_3002, 2, 4, 0, 1, 0, 0, 0, 0, INSN_A, 1, "R3 reserve off by 2");
    send(32'h0000_3008, 2, 4, 0, 1, 0, 0, 0, 0, INSN_A, 1, "R3 reserve aligned");
    idle(1);

    // R4 little-endian
    send(32'h0000_0011, 1, 0, 1, 0, 0, 0, 0, 0, INSN_A, 1, "R4 LE int half odd");
    send(32'h0000_0014, 2, 0, 1, 0, 0, 0, 0, 0, INSN_A, 1, "R4 LE int word aligned");
    send(32'h0000_0024, 3, 1, 1, 0, 0, 0, 0, 0, INSN_B, 0, "R4 LE fp dbl not 8-aligned");
    send(32'h0000_0040, 2, 3, 1, 0, 0, 0, 0, 0, INSN_A, 1, "R4 LE string aligned");
    send(32'h0000_0080, 2, 2, 1, 0, 0, 0, 0, 0, INSN_A, 0, "R4 LE multiple aligned");
    send(32'h0000_0040, 2, 3, 0, 0, 0, 0, 0, 0, INSN_A, 1, "R4 BE string");
    send(32'h0000_0082, 2, 4, 1, 0, 0, 0, 0, 0, INSN_B, 1, "R4 LE reserve misaligned");

    // R5 cache-block zero
    send(32'h0000_5013, 0, 5, 1, 1, 0, 0, 0, 0, INSN_A, 1, "R5 cbz plain page");
    send(32'h0000_5000, 0, 5, 0, 1, 0, 0, 1, 0, INSN_A, 1, "R5 cbz write-through");
    send(32'h0000_5000, 0, 5, 0, 1, 0, 0, 0, 1, INSN_B, 0, "R5 cbz cache-inhibited");

    // R6 address wrap, R7/R8 syndrome patterns
    send(32'hFFFF_FFFD, 2, 2, 0, 1, 0, 0, 0, 0, INSN_A, 1, "R6 multiple dar wraps");
    send(32'h8000_0003, 2, 1, 0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 1, "R7 indexed all ones");
    send(32'h8000_0003, 2, 1, 0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 0, "R8 immediate all ones");
    send(32'h8000_0001, 2, 1, 0, 0, 0, 0, 0, 0, INSN_B, 0, "R8 immediate pattern");

    // R11 unused class codes
    send(32'h0000_0FFF, 3, 6, 1, 1, 0, 0, 1, 1, INSN_A, 1, "R11 class 6");
    send(32'h0000_0FFF, 3, 7, 1, 1, 0, 0, 1, 1, INSN_A, 1, "R11 class 7");
    idle(2);
    check_idle("R9 final idle");

    checks++;
    if (q_fault.size() != 0) begin
      failures++;
      $display("FAIL R9 pending results act=%0d exp=0", q_fault.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule